// File: doc/BRIEF.md
# Stereo Side-by-Side Line Merger

The block joins two frame-locked pixel streams, one from a left camera and one from a right camera, into one frame of twice the width. Each output line carries every pixel of the left line in column order, followed at once by every pixel of the matching right line. A stereo headset in left-right mode, or a downstream video link, can show the result with no further processing.

The two inputs may be offset from each other by up to two pixel clocks. Left pixels pass through a short skew FIFO. Right pixels are written into a single-line buffer and read back as soon as the last left pixel of the line has been sent. Only one line of storage is needed because the cameras are locked in hardware.

Each input line has `LINE_W` pixels and each frame has `LINES` lines (400 and 400 by default). Within a line, pixels arrive on consecutive cycles. The start of each frame is marked on its first pixel. Because each output line takes two input line-times of pixels, the input line period must be at least `2*LINE_W + 2` cycles.

Top module: `stereo_sbs_merge`

## Requirements
- R1: While reset is held, and after it is released until the first input arrives, `out_lv_o`, `out_fv_o` and `ovf_o` are 0.
- R2: Each output line is `LINE_W` left pixels in column order, then `LINE_W` right pixels of the same line in column order. Each input stream counts columns from the pixel flagged as start of frame, wrapping every `LINE_W` pixels.
- R3: `out_lv_o` is high for exactly `2*LINE_W` consecutive cycles per line and low between lines. The first output pixel appears 2 cycles after the cycle in which left pixel 0 of that line is driven.
- R4: Offsetting the right stream by up to 2 cycles in either direction, relative to the left stream, leaves the output content and timing unchanged.
- R5: `out_fv_o` rises together with the first output pixel of a line whose first left pixel carries the start-of-frame flag. It stays high through the last pixel of line `LINES-1`, including the gaps between lines, and falls together with `out_lv_o` after that line.
- R6: If the first pixel of a new right line is written while the previous right line has not yet been fully read out, `ovf_o` goes high 1 cycle later. It then stays high until reset.
- R7: A left pixel arriving while the skew FIFO (`SKEW_DEPTH` entries) is full and is not being popped sets `ovf_o` 1 cycle later.
- R8: With a line period of `2*LINE_W + 2` cycles or more and a right offset within ±2 cycles, `ovf_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_vld_i | input | 1 | Left pixel valid |
| l_sof_i | input | 1 | Left pixel is first of frame |
| l_pix_i | input | PIX_W | Left pixel value |
| r_vld_i | input | 1 | Right pixel valid |
| r_sof_i | input | 1 | Right pixel is first of frame |
| r_pix_i | input | PIX_W | Right pixel value |
| out_lv_o | output | 1 | Output line valid |
| out_fv_o | output | 1 | Output frame valid |
| out_pix_o | output | PIX_W | Output pixel value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Every result has a fixed latency, so the bench keeps a cycle index and computes each expected value from the cycle in which the related stimulus was driven:
- Left pixel `j` of a line is due `j+2` cycles after left pixel 0 was driven.
- Right pixel `j` of that line is due `LINE_W+j+2` cycles after left pixel 0.
- Frame valid spans from the first of those cycles in line 0 to the last one in line `LINES-1`.
- Overflow is due exactly 1 cycle after the offending write.

Inputs are driven and outputs sampled on the falling edge, so each comparison sees registered values that settled half a cycle earlier. Every cycle of the sweep over right offsets and line periods is compared, including the idle cycles between lines and between frames.

// File: rtl/smx_pkg.sv
package smx_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LEFT, PH_RIGHT} phase_e;
endpackage

// File: rtl/smx_skew_fifo.sv
module smx_skew_fifo #(
  parameter int DW    = 11,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PLAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PLAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // sequencer must never drain an empty FIFO
  a_r7_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/smx_line_buf.sv
module smx_line_buf #(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 400
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_vld_i,
  input  logic                      wr_sof_i,
  input  logic [PIX_W-1:0]          wr_pix_i,
  input  logic                      rd_en_i,
  input  logic [$clog2(LINE_W)-1:0] rd_addr_i,
  output logic [PIX_W-1:0]          rd_pix_o,
  output logic                      clash_o
);
  localparam int AW = $clog2(LINE_W);
  localparam logic [AW-1:0] LAST = AW'(LINE_W - 1);

  logic [PIX_W-1:0] mem_q [LINE_W];
  logic [AW-1:0]    wp_q, wr_addr;
  logic             pend_q, line_done, drained;

  assign wr_addr   = wr_sof_i ? '0 : wp_q;
  assign line_done = wr_vld_i && (wr_addr == LAST);
  assign drained   = rd_en_i && (rd_addr_i == LAST);
  // new line begins while the previous one is still waiting to be read
  assign clash_o   = wr_vld_i && (wr_addr == '0) && pend_q && !drained;

  always_ff @(posedge clk_i) begin
    if (wr_vld_i) mem_q[wr_addr] <= wr_pix_i;
    if (rd_en_i)  rd_pix_o <= mem_q[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_vld_i) wp_q <= (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
      if (line_done)    pend_q <= 1'b1;
      else if (drained) pend_q <= 1'b0;
    end
  end

  a_r2_rd_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (rd_addr_i <= LAST));
endmodule

// File: rtl/smx_seq.sv
module smx_seq
  import smx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 400,
  parameter int LINES  = 400
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fifo_empty_i,
  input  logic                      fifo_sof_i,
  input  logic [PIX_W-1:0]          fifo_pix_i,
  output logic                      fifo_pop_o,
  output logic                      rd_en_o,
  output logic [$clog2(LINE_W)-1:0] rd_addr_o,
  output logic                      lv_o,
  output logic                      fv_o,
  output logic                      sel_r_o,
  output logic [PIX_W-1:0]          lpix_o
);
  localparam int AW  = $clog2(LINE_W);
  localparam int LCW = $clog2(LINES + 1);
  localparam logic [AW-1:0]  LAST  = AW'(LINE_W - 1);
  localparam logic [LCW-1:0] LLAST = LCW'(LINES - 1);
  localparam logic [LCW-1:0] LSAT  = LCW'(LINES);

  phase_e         ph_q;
  logic [AW-1:0]  cnt_q;
  logic [LCW-1:0] line_q;
  logic           fv_q, fv_drop_q, lv_q, sel_q;
  logic [PIX_W-1:0] lpix_q;
  logic           start, start_sof, line_end;

  assign start      = (ph_q == PH_IDLE) && !fifo_empty_i;
  assign start_sof  = start && fifo_sof_i;
  assign line_end   = (ph_q == PH_RIGHT) && (cnt_q == LAST);
  assign fifo_pop_o = start || (ph_q == PH_LEFT);
  assign rd_en_o    = (ph_q == PH_RIGHT);
  assign rd_addr_o  = cnt_q;
  assign lv_o       = lv_q;
  assign fv_o       = fv_q;
  assign sel_r_o    = sel_q;
  assign lpix_o     = lpix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) begin
          cnt_q <= AW'(1);
          ph_q  <= PH_LEFT;
        end
        PH_LEFT: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= PH_RIGHT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_RIGHT: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= PH_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_q   <= 1'b0;
      sel_q  <= 1'b0;
      lpix_q <= '0;
    end else begin
      lv_q  <= fifo_pop_o || rd_en_o;
      sel_q <= rd_en_o;
      if (fifo_pop_o) lpix_q <= fifo_pix_i;
    end
  end

  // frame valid drops one edge after the last read so the final pixel is covered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q    <= LSAT;
      fv_q      <= 1'b0;
      fv_drop_q <= 1'b0;
    end else if (start_sof) begin
      line_q    <= '0;
      fv_q      <= 1'b1;
      fv_drop_q <= 1'b0;
    end else begin
      if (fv_drop_q) begin
        fv_q      <= 1'b0;
        fv_drop_q <= 1'b0;
      end
      if (line_end) begin
        if (line_q != LSAT) line_q <= line_q + 1'b1;
        if (fv_q && (line_q == LLAST)) fv_drop_q <= 1'b1;
      end
    end
  end

  // left stream is continuous within a line, so the FIFO never runs dry mid-line
  a_r3_left_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LEFT) |-> !fifo_empty_i);
  a_r5_fv_rise_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fv_q) |-> (lv_q && !sel_q));
  a_r5_fv_fall_after_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fv_q) |-> $past(sel_q));
endmodule

// File: rtl/stereo_sbs_merge.sv
module stereo_sbs_merge #(
  parameter int PIX_W      = 10,
  parameter int LINE_W     = 400,
  parameter int LINES      = 400,
  parameter int SKEW_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l_vld_i,
  input  logic             l_sof_i,
  input  logic [PIX_W-1:0] l_pix_i,
  input  logic             r_vld_i,
  input  logic             r_sof_i,
  input  logic [PIX_W-1:0] r_pix_i,
  output logic             out_lv_o,
  output logic             out_fv_o,
  output logic [PIX_W-1:0] out_pix_o,
  output logic             ovf_o
);
  localparam int AW = $clog2(LINE_W);
  localparam int FW = PIX_W + 1;

  logic [FW-1:0]    fifo_dout;
  logic             fifo_empty, fifo_full, fifo_pop;
  logic             rd_en, clash, sel_r;
  logic [AW-1:0]    rd_addr;
  logic [PIX_W-1:0] rd_pix, lpix;
  logic             ovf_q, fifo_drop;

  smx_skew_fifo #(.DW(FW), .DEPTH(SKEW_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (l_vld_i),
    .din_i   ({l_sof_i, l_pix_i}),
    .pop_i   (fifo_pop),
    .dout_o  (fifo_dout),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  smx_line_buf #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_lbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_vld_i  (r_vld_i),
    .wr_sof_i  (r_sof_i),
    .wr_pix_i  (r_pix_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_pix_o  (rd_pix),
    .clash_o   (clash)
  );

  smx_seq #(.PIX_W(PIX_W), .LINE_W(LINE_W), .LINES(LINES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty),
    .fifo_sof_i   (fifo_dout[FW-1]),
    .fifo_pix_i   (fifo_dout[PIX_W-1:0]),
    .fifo_pop_o   (fifo_pop),
    .rd_en_o      (rd_en),
    .rd_addr_o    (rd_addr),
    .lv_o         (out_lv_o),
    .fv_o         (out_fv_o),
    .sel_r_o      (sel_r),
    .lpix_o       (lpix)
  );

  assign fifo_drop = l_vld_i && fifo_full && !fifo_pop;
  assign out_pix_o = sel_r ? rd_pix : lpix;
  assign ovf_o     = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_q <= 1'b0;
    else if (fifo_drop || clash) ovf_q <= 1'b1;
  end

  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r6_clash_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_vld_i && clash) |=> ovf_o);
endmodule

// File: tb/stereo_sbs_merge_bench.sv
module stereo_sbs_merge_bench;
  localparam int PW = 10, LW = 8, NL = 3, SD = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic l_vld_i = 0, l_sof_i = 0, r_vld_i = 0, r_sof_i = 0;
  logic [PW-1:0] l_pix_i = '0, r_pix_i = '0;
  logic out_lv_o, out_fv_o, ovf_o;
  logic [PW-1:0] out_pix_o;

  always #2 clk_i = ~clk_i;

  stereo_sbs_merge #(.PIX_W(PW), .LINE_W(LW), .LINES(NL), .SKEW_DEPTH(SD)) u_stereo_sbs_merge (
    .clk_i, .rst_ni, .l_vld_i, .l_sof_i, .l_pix_i, .r_vld_i, .r_sof_i, .r_pix_i,
    .out_lv_o, .out_fv_o, .out_pix_o, .ovf_o);

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit mon_en = 0;
  int ln_st[64], ln_f[64], ln_l[64];
  int fr_s[32], fr_e[32];
  int nln = 0, nfr = 0, mi = 0, mf = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [PW-1:0] enc(int side, int f, int l, int c);
    logic [31:0] s = side, fv = f, lv = l, cv = c;
    return {s[0], fv[2:0], lv[1:0], cv[3:0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle output model
  always @(negedge clk_i) begin
    if (mon_en) begin
      bit e_lv, e_fv;
      logic [PW-1:0] e_pix;
      int pos;
      e_lv = 0; e_pix = '0;
      if (mi < nln && cyc >= ln_st[mi] + 2 && cyc < ln_st[mi] + 2 + 2*LW) begin
        e_lv = 1;
        pos = cyc - ln_st[mi] - 2;
        e_pix = (pos < LW) ? enc(0, ln_f[mi], ln_l[mi], pos) : enc(1, ln_f[mi], ln_l[mi], pos - LW);
      end
      chk(out_lv_o == e_lv, "R3 line valid", out_lv_o, e_lv);
      if (e_lv) chk(out_pix_o == e_pix, "R2 R4 pixel", out_pix_o, e_pix);
      if (mi < nln && cyc == ln_st[mi] + 1 + 2*LW) mi++;
      e_fv = (mf < nfr && cyc >= fr_s[mf] && cyc <= fr_e[mf]);
      chk(out_fv_o == e_fv, "R5 frame valid", out_fv_o, e_fv);
      if (mf < nfr && cyc == fr_e[mf]) mf++;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      l_vld_i = 0; l_sof_i = 0; r_vld_i = 0; r_sof_i = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; l_vld_i = 0; l_sof_i = 0; r_vld_i = 0; r_sof_i = 0;
    idle(2);
    rst_ni = 1;
    idle(1);
  endtask

  // s: right offset in cycles relative to left, p: line period
  task automatic send_frame(int s, int p, int f);
    int base = 0, lo, ro;
    lo = (s < 0) ? -s : 0;
    ro = lo + s;
    for (int k = 0; k < NL*p; k++) begin
      int l, kk;
      @(negedge clk_i);
      if (k == 0) begin
        base = cyc;
        fr_s[nfr] = base + lo + 2;
        fr_e[nfr] = base + (NL-1)*p + lo + 1 + 2*LW;
        nfr++;
      end
      l = k / p; kk = k % p;
      if (kk == 0) begin
        ln_st[nln] = base + l*p + lo; ln_f[nln] = f % 8; ln_l[nln] = l; nln++;
      end
      l_vld_i = (kk >= lo && kk < lo + LW);
      l_sof_i = l_vld_i && l == 0 && kk == lo;
      l_pix_i = l_vld_i ? enc(0, f % 8, l, kk - lo) : '0;
      r_vld_i = (kk >= ro && kk < ro + LW);
      r_sof_i = r_vld_i && l == 0 && kk == ro;
      r_pix_i = r_vld_i ? enc(1, f % 8, l, kk - ro) : '0;
    end
    idle(1);
  endtask

  initial begin
    int fid = 0;
    // R1: outputs quiet in and just after reset
    idle(3);
    chk(out_lv_o == 0 && out_fv_o == 0 && ovf_o == 0, "R1 in reset", {out_lv_o, out_fv_o, ovf_o}, 0);
    rst_ni = 1;
    idle(3);
    chk(out_lv_o == 0 && out_fv_o == 0 && ovf_o == 0, "R1 after reset", {out_lv_o, out_fv_o, ovf_o}, 0);

    // R2 R3 R4 R5 R8: sweep of right offset and line period
    mon_en = 1;
    for (int s = -2; s <= 2; s++) begin
      send_frame(s, 2*LW + 2, fid); fid++;
      idle(5);
      send_frame(s, 2*LW + 5, fid); fid++;
    end
    // back-to-back frames at minimum period and skew
    send_frame(-2, 2*LW + 2, fid); fid++;
    send_frame(2, 2*LW + 2, fid); fid++;
    idle(2*LW + 8);
    mon_en = 0;
    chk(mi == nln, "R3 all lines emitted", mi, nln);
    chk(ovf_o == 0, "R8 no overflow in legal sweep", ovf_o, 0);

    // R6: second right line while the first is still pending
    do_reset();
    for (int j = 0; j < LW; j++) begin
      @(negedge clk_i);
      r_vld_i = 1; r_sof_i = (j == 0); r_pix_i = enc(1, 0, 0, j);
    end
    @(negedge clk_i);
    chk(ovf_o == 0, "R6 before clash", ovf_o, 0);
    r_vld_i = 1; r_sof_i = 0; r_pix_i = enc(1, 0, 1, 0);
    @(negedge clk_i);
    chk(ovf_o == 1, "R6 clash flagged", ovf_o, 1);
    r_vld_i = 0;
    idle(6);
    chk(ovf_o == 1, "R6 flag sticky", ovf_o, 1);
    chk(out_lv_o == 0, "R6 no output without left", out_lv_o, 0);

    // R7: left FIFO overrun while right half is being sent
    do_reset();
    for (int j = 0; j < LW; j++) begin
      @(negedge clk_i);
      l_vld_i = 1; l_sof_i = (j == 0); l_pix_i = enc(0, 0, 0, j);
      r_vld_i = 1; r_sof_i = (j == 0); r_pix_i = enc(1, 0, 0, j);
    end
    for (int k = 0; k <= SD + 1; k++) begin
      @(negedge clk_i);
      chk(ovf_o == (k >= SD + 1), "R7 FIFO overrun timing", ovf_o, (k >= SD + 1));
      l_vld_i = 1; l_sof_i = 0; l_pix_i = enc(0, 0, 1, k);
      r_vld_i = 0; r_sof_i = 0;
    end
    idle(1);
    chk(ovf_o == 1, "R7 overrun flagged", ovf_o, 1);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule